// File: doc/BRIEF.md
# Extended ALU with Operation Decoder

This block is the arithmetic core of a single-cycle 32-bit datapath in the load/store, register-to-register style. It receives a 3-bit operation class from the main controller, the 6-bit function field of register-format instructions and two operands. The second operand arrives already sign-extended when the instruction carries an immediate. The block turns the class and the function field into a 4-bit ALU control code. It computes the result and raises a zero flag, which the branch logic uses.

The operation class is wide enough to name each immediate operation directly: add-immediate, and-immediate, or-immediate and xor-immediate. For the three logical immediates the block clears the upper half of operand B again, so they see a zero-extended immediate. A dedicated not-equal code makes the zero flag mean "operands differ". The branch path that takes its decision from zero then serves both branch-if-equal and branch-if-not-equal without change. Function codes that are not recognised fall back to addition and raise an illegal-operation flag. The block is purely combinational.

Top module: `aluExtUnit`

## Requirements
- R1: Operation class 0 gives control code 0x2 (addition, result = A + B). Class 1 gives code 0x6 (subtraction, result = A - B). In both classes the function field has no effect.
- R2: Class 2 decodes the function field. 0x20 selects add (code 0x2), 0x22 selects subtract (0x6), 0x24 selects AND (0x0), 0x25 selects OR (0x1), 0x26 selects XOR (0x3), 0x27 selects NOR (0xC) and 0x2A selects set-less-than (0x7). Operand B is used unmodified.
- R3: Under class 2, any function value outside that list gives code 0x2 with the addition result and sets illegalOp to 1. In every other case illegalOp is 0.
- R4: Class 3 gives code 0x2 and adds operand B as received, with its sign-extended upper half kept.
- R5: Class 4 gives code 0x0 (AND), class 5 gives code 0x1 (OR) and class 6 gives code 0x3 (XOR). All three use operand B with bits 31:16 forced to zero.
- R6: Class 7 gives code 0xA. The result is A - B, and zero is 1 exactly when A differs from B.
- R7: For every code other than 0xA, zero is 1 exactly when the 32-bit result is all zeros.
- R8: Set-less-than compares the operands as signed two's-complement values. It gives result 1 when A < B and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aluOp | input | 3 | Operation class from the main controller |
| funct | input | 6 | Function field of register-format instructions |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand (sign-extended immediate for immediate forms) |
| aluCtrl | output | 4 | Decoded ALU control code |
| result | output | 32 | Operation result |
| zero | output | 1 | Zero flag, or inequality flag under code 0xA |
| illegalOp | output | 1 | Unrecognised function field under class 2 |

## Verification
The block holds no state, so any decode fault shows at the ports in the same evaluation as the input change. A wrong control code appears on aluCtrl and usually in the result as well. A wrong extension choice shows only when bit 15 of the immediate is set, so the vectors put ones in the upper half of B. The polarity of the zero flag differs between code 0xA and all other codes. It is therefore checked with both equal and unequal operands, and with results that are zero only after zero extension.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;

  typedef enum logic [3:0] {
    CODE_AND = 4'h0,
    CODE_OR  = 4'h1,
    CODE_ADD = 4'h2,
    CODE_XOR = 4'h3,
    CODE_SUB = 4'h6,
    CODE_SLT = 4'h7,
    CODE_NEQ = 4'hA,
    CODE_NOR = 4'hC
  } aluCode_e;

  typedef struct packed {
    aluCode_e code;
    logic     zeroExtB;
    logic     invertZero;
  } aluStrobes_t;

endpackage

// File: rtl/aluDecoder.sv
module aluDecoder
  import alu_ext_pkg::*;
#(
  parameter int OP_W    = 3,
  parameter int FUNCT_W = 6
) (
  input  logic [OP_W-1:0]    aluOp,
  input  logic [FUNCT_W-1:0] funct,
  output aluStrobes_t        strobes,
  output logic               illegalOp
);

  aluCode_e rCode;
  logic     rBad;

  always_comb begin
    rBad = 1'b0;
    unique case (funct)
      FUNCT_W'(6'h20): rCode = CODE_ADD;
      FUNCT_W'(6'h22): rCode = CODE_SUB;
      FUNCT_W'(6'h24): rCode = CODE_AND;
      FUNCT_W'(6'h25): rCode = CODE_OR;
      FUNCT_W'(6'h26): rCode = CODE_XOR;
      FUNCT_W'(6'h27): rCode = CODE_NOR;
      FUNCT_W'(6'h2A): rCode = CODE_SLT;
      default: begin
        rCode = CODE_ADD;
        rBad  = 1'b1;
      end
    endcase
  end

  always_comb begin
    strobes.code       = CODE_ADD;
    strobes.zeroExtB   = 1'b0;
    strobes.invertZero = 1'b0;
    illegalOp          = 1'b0;
    case (aluOp)
      OP_W'(0): strobes.code = CODE_ADD;
      OP_W'(1): strobes.code = CODE_SUB;
      OP_W'(2): begin
        strobes.code = rCode;
        illegalOp    = rBad;
      end
      OP_W'(3): strobes.code = CODE_ADD;
      OP_W'(4): begin
        strobes.code     = CODE_AND;
        strobes.zeroExtB = 1'b1;
      end
      OP_W'(5): begin
        strobes.code     = CODE_OR;
        strobes.zeroExtB = 1'b1;
      end
      OP_W'(6): begin
        strobes.code     = CODE_XOR;
        strobes.zeroExtB = 1'b1;
      end
      OP_W'(7): begin
        strobes.code       = CODE_NEQ;
        strobes.invertZero = 1'b1;
      end
      default: illegalOp = 1'b1;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import alu_ext_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              zero
);

  localparam int UPPER_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] bEff;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic              less;

  generate
    if (UPPER_W > 0) begin : g_zext
      assign bEff = strobes.zeroExtB ? {{UPPER_W{1'b0}}, opB[IMM_W-1:0]} : opB;
    end else begin : g_nozext
      assign bEff = opB;
    end
  endgenerate

  assign sum  = opA + bEff;
  assign diff = opA - bEff;
  assign less = $signed(opA) < $signed(bEff);

  always_comb begin
    case (strobes.code)
      CODE_AND: result = opA & bEff;
      CODE_OR:  result = opA | bEff;
      CODE_XOR: result = opA ^ bEff;
      CODE_NOR: result = ~(opA | bEff);
      CODE_SUB: result = diff;
      CODE_NEQ: result = diff;
      CODE_SLT: result = {{(DATA_W-1){1'b0}}, less};
      default:  result = sum;
    endcase
  end

  assign zero = strobes.invertZero ? (diff != '0) : (result == '0);

endmodule

// File: rtl/aluExtUnit.sv
module aluExtUnit
  import alu_ext_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int OP_W    = 3,
  parameter int FUNCT_W = 6
) (
  input  logic [OP_W-1:0]    aluOp,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  output logic [3:0]         aluCtrl,
  output logic [DATA_W-1:0]  result,
  output logic               zero,
  output logic               illegalOp
);

  aluStrobes_t strobes;

  aluDecoder #(.OP_W(OP_W), .FUNCT_W(FUNCT_W)) u_dec (
    .aluOp     (aluOp),
    .funct     (funct),
    .strobes   (strobes),
    .illegalOp (illegalOp)
  );

  aluDatapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .zero    (zero)
  );

  assign aluCtrl = strobes.code;

endmodule

// File: rtl/aluExtUnit_checker.sv
module aluExtUnit_checker #(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 3,
  parameter int FUNCT_W = 6
) (
  input logic [OP_W-1:0]    aluOp,
  input logic [FUNCT_W-1:0] funct,
  input logic [DATA_W-1:0]  opA,
  input logic [DATA_W-1:0]  opB,
  input logic [3:0]         aluCtrl,
  input logic [DATA_W-1:0]  result,
  input logic               zero,
  input logic               illegalOp
);

  always_comb begin
    if (aluCtrl == 4'hA) begin
      AST_NEQ_ZERO: assert (zero == (opA != opB)); // R6
    end else begin
      AST_ZERO_RESULT: assert (zero == (result == '0)); // R7
    end
    if (illegalOp) begin
      AST_ILLEGAL_ADD: assert (aluOp == OP_W'(2) && aluCtrl == 4'h2); // R3
    end
    if (aluOp == OP_W'(7)) begin
      AST_NEQ_CODE: assert (aluCtrl == 4'hA); // R6
    end
    if (aluOp == OP_W'(4)) begin
      AST_ANDI_UPPER: assert (result[DATA_W-1:16] == '0); // R5
    end
    if (aluOp == OP_W'(5) || aluOp == OP_W'(6)) begin
      AST_ORXOR_UPPER: assert (result[DATA_W-1:16] == opA[DATA_W-1:16]); // R5
    end
    if (aluOp == OP_W'(0) || aluOp == OP_W'(3)) begin
      AST_ADD_CLASS: assert (aluCtrl == 4'h2 && result == opA + opB); // R1 R4
    end
  end

endmodule

bind aluExtUnit aluExtUnit_checker #(
  .DATA_W(DATA_W), .OP_W(OP_W), .FUNCT_W(FUNCT_W)
) u_chk (
  .aluOp(aluOp), .funct(funct), .opA(opA), .opB(opB),
  .aluCtrl(aluCtrl), .result(result), .zero(zero), .illegalOp(illegalOp)
);

// File: tb/sim_aluExtUnit.sv
module sim_aluExtUnit;

  typedef struct packed {
    logic [2:0]  op;
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  ctl;
    logic [31:0] res;
    logic        z;
    logic        ill;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 6'h00, 32'h00000010, 32'hFFFFFFFC, 4'h2, 32'h0000000C, 1'b0, 1'b0}, // R1
    '{3'd1, 6'h00, 32'h00000005, 32'h00000005, 4'h6, 32'h00000000, 1'b1, 1'b0}, // R1 R7
    '{3'd1, 6'h2A, 32'h00000005, 32'h00000003, 4'h6, 32'h00000002, 1'b0, 1'b0}, // R1
    '{3'd2, 6'h20, 32'h00000007, 32'h00000009, 4'h2, 32'h00000010, 1'b0, 1'b0}, // R2
    '{3'd2, 6'h22, 32'h00000003, 32'h00000005, 4'h6, 32'hFFFFFFFE, 1'b0, 1'b0}, // R2
    '{3'd2, 6'h24, 32'hF0F0F0F0, 32'hFFFF0000, 4'h0, 32'hF0F00000, 1'b0, 1'b0}, // R2
    '{3'd2, 6'h25, 32'h0F000000, 32'h000000F0, 4'h1, 32'h0F0000F0, 1'b0, 1'b0}, // R2
    '{3'd2, 6'h26, 32'hAAAAAAAA, 32'hFFFFFFFF, 4'h3, 32'h55555555, 1'b0, 1'b0}, // R2
    '{3'd2, 6'h27, 32'h0F0F0F0F, 32'hF0F0F0F0, 4'hC, 32'h00000000, 1'b1, 1'b0}, // R2 R7
    '{3'd2, 6'h2A, 32'hFFFFFFFF, 32'h00000001, 4'h7, 32'h00000001, 1'b0, 1'b0}, // R8
    '{3'd2, 6'h2A, 32'h00000001, 32'hFFFFFFFF, 4'h7, 32'h00000000, 1'b1, 1'b0}, // R8
    '{3'd2, 6'h3F, 32'h00000002, 32'h00000003, 4'h2, 32'h00000005, 1'b0, 1'b1}, // R3
    '{3'd3, 6'h22, 32'h0000000A, 32'hFFFFFFFF, 4'h2, 32'h00000009, 1'b0, 1'b0}, // R4
    '{3'd4, 6'h00, 32'hFFFFFFFF, 32'hFFFF8001, 4'h0, 32'h00008001, 1'b0, 1'b0}, // R5
    '{3'd5, 6'h00, 32'h12340000, 32'hFFFF8000, 4'h1, 32'h12348000, 1'b0, 1'b0}, // R5
    '{3'd6, 6'h00, 32'hFFFFFFFF, 32'hFFFF8000, 4'h3, 32'hFFFF7FFF, 1'b0, 1'b0}, // R5
    '{3'd6, 6'h00, 32'h00008000, 32'hFFFF8000, 4'h3, 32'h00000000, 1'b1, 1'b0}, // R5 R7
    '{3'd7, 6'h00, 32'h00000005, 32'h00000005, 4'hA, 32'h00000000, 1'b0, 1'b0}, // R6
    '{3'd7, 6'h00, 32'h00000005, 32'h00000006, 4'hA, 32'hFFFFFFFF, 1'b1, 1'b0}, // R6
    '{3'd2, 6'h24, 32'hFFFFFFFF, 32'hFFFF8000, 4'h0, 32'hFFFF8000, 1'b0, 1'b0}  // R2 R5
  };

  logic        clk = 1'b0;
  logic [2:0]  aluOp;
  logic [5:0]  funct;
  logic [31:0] opA, opB, result;
  logic [3:0]  aluCtrl;
  logic        zero, illegalOp;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always #10 clk = ~clk;

  aluExtUnit u0 (
    .aluOp(aluOp), .funct(funct), .opA(opA), .opB(opB),
    .aluCtrl(aluCtrl), .result(result), .zero(zero), .illegalOp(illegalOp)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    aluOp = op; funct = fn; opA = a; opB = b;
    @(negedge clk);
  endtask

  initial begin
    aluOp = '0; funct = '0; opA = '0; opB = '0;
    @(negedge clk);
    check("R1", "idle ctrl", {28'd0, aluCtrl}, 32'h2);
    check("R3", "idle illegal", {31'd0, illegalOp}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].fn, VECS[i].a, VECS[i].b);
      check("R1-R8 vec", $sformatf("ctrl v%0d", i), {28'd0, aluCtrl}, {28'd0, VECS[i].ctl});
      check("R1-R8 vec", $sformatf("result v%0d", i), result, VECS[i].res);
      check("R6/R7 vec", $sformatf("zero v%0d", i), {31'd0, zero}, {31'd0, VECS[i].z});
      check("R3 vec", $sformatf("illegal v%0d", i), {31'd0, illegalOp}, {31'd0, VECS[i].ill});
    end

    // R3: full function sweep under class 2
    for (int f = 0; f < 64; f++) begin
      logic known;
      known = (f == 'h20) || (f == 'h22) || (f == 'h24) || (f == 'h25) ||
              (f == 'h26) || (f == 'h27) || (f == 'h2A);
      apply(3'd2, 6'(f), 32'h1, 32'h1);
      check("R3", $sformatf("illegal funct %0h", f), {31'd0, illegalOp}, {31'd0, !known});
    end

    // R1: function field ignored outside class 2
    for (int f = 0; f < 64; f += 9) begin
      apply(3'd1, 6'(f), 32'h9, 32'h4);
      check("R1", "sub ignores funct", result, 32'h5);
      check("R3", "no illegal class 1", {31'd0, illegalOp}, 32'd0);
    end

    // R6: unequal operands only in the upper half
    apply(3'd7, 6'h00, 32'h80000000, 32'h00000000);
    check("R6", "neq upper diff", {31'd0, zero}, 32'd1);
    // R7: beq with same operands in class 1
    apply(3'd1, 6'h00, 32'hDEADBEEF, 32'hDEADBEEF);
    check("R7", "beq equal zero", {31'd0, zero}, 32'd1);
    // R8: signed boundary
    apply(3'd2, 6'h2A, 32'h80000000, 32'h7FFFFFFF);
    check("R8", "slt min<max", result, 32'h1);
    // R4: add-immediate keeps sign extension
    apply(3'd3, 6'h00, 32'h00010000, 32'hFFFF8000);
    check("R4", "addi negative imm", result, 32'h00008000);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule